// File: doc/BRIEF.md
# Frequency-Change Watchdog with Recovery Lock

This block supervises a programmable clock generator. Software selects the output frequency by writing a selection code through a small register interface. When the watchdog is enabled, every accepted frequency change arms a countdown. Software is expected to confirm that the system survived the change by clearing the enable bit before the countdown runs out. If the countdown expires, the block puts a stored recovery selection on the frequency-select output and enters a locked recovery mode. In that mode, further frequency writes are refused. It can also raise a system reset pulse.

The countdown is measured in units of a prescaler tick. The tick is divided down from the reference clock, using one of two divisors chosen by a control bit: a short unit nominally 150 ms and a long unit nominally 2.5 s. The timeout field is five bits wide. A value of 0 stands for 32 units, so the field covers 1 to 32 units. A second reset-enable bit asks for a reset pulse after every accepted frequency change, independent of the watchdog.

Top module: `freq_watchdog`

## Requirements
- R1: After synchronous reset, `freq_sel_o` equals `RESET_SEL` (0 by default), `recovery_o` and `sys_rst_o` are 0, and every register reads back 0.
- R2: A write to address 0 outside recovery mode is accepted: `freq_sel_o` takes `wr_data[SEL_W-1:0]` in the cycle after the write. Setting the enable bit alone starts no countdown, so no timeout follows without a frequency change.
- R3: With the enable bit (address 2 bit 0) set, an accepted frequency change at clock edge k makes the block expire exactly at edge k + units*DIV. At that edge `freq_sel_o` becomes the recovery selection (address 1), `recovery_o` goes to 1, and the status bit (address 2 bit 7) reads 1. One cycle earlier, none of these has happened yet.
- R4: While `recovery_o` is 1, writes to address 0 change neither `freq_sel_o` nor produce a reset pulse, and writing the enable bit as 1 keeps the lock.
- R5: Writing address 2 with bit 0 clear stops the countdown, reloads it with the programmed value, and clears `recovery_o`. After that, frequency writes are accepted again.
- R6: The status bit is set on expiry. A control write with bit 7 = 1 clears it, and one with bit 7 = 0 leaves it set.
- R7: Address 2 bit 1 selects the unit length: 0 gives `SHORT_DIV` reference cycles, 1 gives `LONG_DIV`.
- R8: A timeout value of 0 (address 3, bits 4:0) counts 32 units.
- R9: With address 2 bit 2 set, expiry drives `sys_rst_o` high for exactly `RST_WIDTH` cycles starting after the expiry edge. With the bit clear, expiry gives no pulse.
- R10: With address 2 bit 3 set, every accepted frequency change drives `sys_rst_o` high for `RST_WIDTH` cycles starting after the write edge.
- R11: A frequency change accepted while the countdown is running restarts it from the full timeout value.
- R12: Registers read back combinationally on `rd_data`. Address 0 holds the active selection, address 1 the recovery selection, address 2 the control bits {status at bit 7, bits 3:0 as above}, and address 3 the timeout in bits 4:0. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data |
| freq_sel_o | output | SEL_W | Active frequency selection |
| recovery_o | output | 1 | Locked recovery mode flag |
| sys_rst_o | output | 1 | Active-high system reset pulse |

## Verification
The hardest situation to reach is a restart of a countdown that is already running. The second change has to land after some units have already elapsed. Expiry must then come a full period after that second write, not after the first. The stimulus writes a new selection eight cycles into a twelve-cycle countdown. It then checks one cycle before and exactly at the restarted deadline. A second hard case is recovery mode itself. The bench can only get there through an expiry, and it then probes the lock with a refused write made while the reset-on-change bit is set.

// File: rtl/fcwd_pkg.sv
package fcwd_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int TO_W   = 5;
    localparam int UNIT_W = TO_W + 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_FSEL  = 2'd0,
        REG_RECOV = 2'd1,
        REG_CTRL  = 2'd2,
        REG_TMO   = 2'd3
    } reg_addr_e;

    localparam int CB_EN   = 0;
    localparam int CB_PRE  = 1;
    localparam int CB_RTO  = 2;
    localparam int CB_RCHG = 3;
    localparam int CB_STAT = 7;

    typedef struct packed {
        logic rst_chg;
        logic rst_to;
        logic pre_long;
        logic wd_en;
    } ctrl_t;

    typedef enum logic { CD_IDLE = 1'b0, CD_RUN = 1'b1 } cd_state_e;
    typedef enum logic { MODE_NORMAL = 1'b0, MODE_RECOVERY = 1'b1 } mode_e;

    function automatic logic [UNIT_W-1:0] units_of(input logic [TO_W-1:0] v);
        if (v == '0)
            return UNIT_W'(1 << TO_W);
        return {1'b0, v};
    endfunction

    function automatic ctrl_t ctrl_decode(input logic [DATA_W-1:0] b);
        ctrl_t c;
        c.wd_en    = b[CB_EN];
        c.pre_long = b[CB_PRE];
        c.rst_to   = b[CB_RTO];
        c.rst_chg  = b[CB_RCHG];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_encode(input ctrl_t c, input logic stat);
        logic [DATA_W-1:0] b;
        b          = '0;
        b[CB_EN]   = c.wd_en;
        b[CB_PRE]  = c.pre_long;
        b[CB_RTO]  = c.rst_to;
        b[CB_RCHG] = c.rst_chg;
        b[CB_STAT] = stat;
        return b;
    endfunction
endpackage

// File: rtl/fcwd_prescaler.sv
module fcwd_prescaler #(
    parameter int SHORT_DIV = 150000,
    parameter int LONG_DIV  = 2500000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic pre_long,
    output logic tick
);
    localparam int MAXD = (LONG_DIV > SHORT_DIV) ? LONG_DIV : SHORT_DIV;
    localparam int CW   = $clog2(MAXD + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = pre_long ? CW'(LONG_DIV - 1) : CW'(SHORT_DIV - 1);
        tick  = run && (cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    generate
        if (SHORT_DIV > 1 && LONG_DIV > 1) begin : g_gap
            // R7
            tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/fcwd_countdown.sv
module fcwd_countdown
    import fcwd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stop,
    input  logic              start,
    input  logic              tick,
    input  logic [UNIT_W-1:0] units,
    output logic              running,
    output logic              expire
);
    cd_state_e         state;
    logic [UNIT_W-1:0] remain;

    always_comb begin
        running = (state == CD_RUN);
        expire  = running && tick && (remain == UNIT_W'(1)) && !stop && !start;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CD_IDLE;
            remain <= '0;
        end else if (stop) begin
            state  <= CD_IDLE;
            remain <= units;
        end else if (start) begin
            state  <= CD_RUN;
            remain <= units;
        end else if (expire) begin
            state  <= CD_IDLE;
            remain <= units;
        end else if (running && tick) begin
            remain <= remain - 1'b1;
        end
    end

    // R11
    restart_load_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> (state == CD_RUN) && (remain == $past(units)));

    // R8
    run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (remain != '0) && (remain <= UNIT_W'(1 << TO_W)));
endmodule

// File: rtl/fcwd_rst_pulse.sv
module fcwd_rst_pulse #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic pulse_o
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(WIDTH);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign pulse_o = (cnt != '0);

    // R9
    pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(1) && !start) |=> !pulse_o);

    // R10
    pulse_begin_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> pulse_o);
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
    import fcwd_pkg::*;
#(
    parameter int SEL_W     = 5,
    parameter int RESET_SEL = 0,
    parameter int SHORT_DIV = 150000,
    parameter int LONG_DIV  = 2500000,
    parameter int RST_WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEL_W-1:0]  freq_sel_o,
    output logic              recovery_o,
    output logic              sys_rst_o
);
    logic [SEL_W-1:0] fsel_q;
    logic [SEL_W-1:0] rec_sel_q;
    ctrl_t            ctrl_q;
    logic [TO_W-1:0]  tmo_q;
    logic             status_q;
    mode_e            mode;

    logic wr_fsel, wr_recov, wr_ctrl, wr_tmo;
    logic accept_chg, disable_wr, cd_start;
    logic tick, running, expire, pulse_start;
    logic [UNIT_W-1:0] units;

    always_comb begin
        wr_fsel     = wr_en && (wr_addr == REG_FSEL);
        wr_recov    = wr_en && (wr_addr == REG_RECOV);
        wr_ctrl     = wr_en && (wr_addr == REG_CTRL);
        wr_tmo      = wr_en && (wr_addr == REG_TMO);
        accept_chg  = wr_fsel && (mode == MODE_NORMAL);
        disable_wr  = wr_ctrl && !wr_data[CB_EN];
        cd_start    = accept_chg && ctrl_q.wd_en;
        units       = units_of(tmo_q);
        pulse_start = (accept_chg && ctrl_q.rst_chg) || (expire && ctrl_q.rst_to);
    end

    fcwd_prescaler #(
        .SHORT_DIV (SHORT_DIV),
        .LONG_DIV  (LONG_DIV)
    ) u_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .restart  (cd_start),
        .pre_long (ctrl_q.pre_long),
        .tick     (tick)
    );

    fcwd_countdown u_count (
        .clk     (clk),
        .rst     (rst),
        .stop    (disable_wr),
        .start   (cd_start),
        .tick    (tick),
        .units   (units),
        .running (running),
        .expire  (expire)
    );

    fcwd_rst_pulse #(
        .WIDTH (RST_WIDTH)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .start   (pulse_start),
        .pulse_o (sys_rst_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsel_q    <= SEL_W'(RESET_SEL);
            rec_sel_q <= '0;
            ctrl_q    <= '0;
            tmo_q     <= '0;
            status_q  <= 1'b0;
            mode      <= MODE_NORMAL;
        end else begin
            if (expire)
                fsel_q <= rec_sel_q;
            else if (accept_chg)
                fsel_q <= wr_data[SEL_W-1:0];

            if (wr_recov)
                rec_sel_q <= wr_data[SEL_W-1:0];
            if (wr_ctrl)
                ctrl_q <= ctrl_decode(wr_data);
            if (wr_tmo)
                tmo_q <= wr_data[TO_W-1:0];

            if (expire)
                status_q <= 1'b1;
            else if (wr_ctrl && wr_data[CB_STAT])
                status_q <= 1'b0;

            if (disable_wr)
                mode <= MODE_NORMAL;
            else if (expire)
                mode <= MODE_RECOVERY;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            REG_FSEL:  rd_data[SEL_W-1:0] = fsel_q;
            REG_RECOV: rd_data[SEL_W-1:0] = rec_sel_q;
            REG_CTRL:  rd_data = ctrl_encode(ctrl_q, status_q);
            REG_TMO:   rd_data[TO_W-1:0] = tmo_q;
            default:   rd_data = '0;
        endcase
    end

    assign freq_sel_o = fsel_q;
    assign recovery_o = (mode == MODE_RECOVERY);

    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (recovery_o && !wr_ctrl) |=> $stable(freq_sel_o));

    // R3
    recov_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(recovery_o) |-> (freq_sel_o == $past(rec_sel_q)));

    // R6
    stat_set_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> status_q);

    // R5
    unlock_chk: assert property (@(posedge clk) disable iff (rst)
        disable_wr |=> !recovery_o);

    // R10
    chg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (accept_chg && ctrl_q.rst_chg) |=> sys_rst_o);
endmodule

// File: tb/freq_watchdog_bench.sv
module freq_watchdog_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SDIV = 4;
    localparam int LDIV = 7;
    localparam int RW   = 3;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic [4:0] freq_sel_o;
    logic       recovery_o;
    logic       sys_rst_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    freq_watchdog #(
        .SEL_W(5), .RESET_SEL(0), .SHORT_DIV(SDIV), .LONG_DIV(LDIV), .RST_WIDTH(RW)
    ) u_freq_watchdog (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .freq_sel_o(freq_sel_o),
        .recovery_o(recovery_o), .sys_rst_o(sys_rst_o)
    );

    // {addr, write data, expected readback}
    localparam logic [17:0] VEC [6] = '{
        {2'd1, 8'h05, 8'h05},
        {2'd3, 8'hFF, 8'h1F},
        {2'd3, 8'h03, 8'h03},
        {2'd2, 8'h8E, 8'h0E},
        {2'd2, 8'h00, 8'h00},
        {2'd0, 8'h09, 8'h09}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_len(output int hi);
        hi = 0;
        while (sys_rst_o && hi < 20) begin
            hi++;
            idle(1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int hi;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        idle(3);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        check("R1 freq_sel", freq_sel_o, 0);
        check("R1 recovery", recovery_o, 0);
        check("R1 sys_rst", sys_rst_o, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check("R1 readback", d, 0);
        end

        // R12 register table
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(VEC[i][17:16], d);
            check("R12 readback", d, VEC[i][7:0]);
        end
        check("R2 accepted change", freq_sel_o, 5'h09);

        // R2 enable alone starts nothing
        wr(2'd2, 8'h01);
        idle(200);
        check("R2 no timeout without change", recovery_o, 0);
        rd(2'd2, d);
        check("R2 status clear", d, 8'h01);

        // R3 / R7 short unit expiry: 3 units * 4
        wr(2'd0, 8'h0A);
        check("R2 freq write", freq_sel_o, 5'h0A);
        idle(11);
        check("R3 not yet locked", recovery_o, 0);
        check("R3 not yet recovered", freq_sel_o, 5'h0A);
        idle(1);
        check("R3 locked", recovery_o, 1);
        check("R3 recovery sel", freq_sel_o, 5'h05);
        check("R9 no pulse when disabled", sys_rst_o, 0);
        rd(2'd2, d);
        check("R3 status set", d[7], 1);

        // R4 lock
        wr(2'd2, 8'h09);
        wr(2'd0, 8'h11);
        check("R4 write ignored", freq_sel_o, 5'h05);
        check("R4 no change pulse", sys_rst_o, 0);
        check("R4 still locked", recovery_o, 1);
        rd(2'd2, d);
        check("R6 write 0 keeps status", d[7], 1);
        wr(2'd2, 8'h89);
        rd(2'd2, d);
        check("R6 write 1 clears", d[7], 0);
        check("R4 lock kept with enable 1", recovery_o, 1);

        // R5 unlock
        wr(2'd2, 8'h00);
        check("R5 unlocked", recovery_o, 0);
        wr(2'd0, 8'h12);
        check("R5 change accepted", freq_sel_o, 5'h12);
        idle(60);
        check("R5 no timer after disable", recovery_o, 0);

        // R10 change pulse
        wr(2'd2, 8'h08);
        wr(2'd0, 8'h13);
        pulse_len(hi);
        check("R10 pulse width", hi, RW);

        // R11 restart while running
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h14);
        idle(8);
        wr(2'd0, 8'h15);
        idle(11);
        check("R11 not expired before restarted deadline", recovery_o, 0);
        idle(1);
        check("R11 expired at restarted deadline", recovery_o, 1);
        wr(2'd2, 8'h00);

        // R7 long unit + R9 timeout pulse: 2 units * 7
        wr(2'd3, 8'h02);
        wr(2'd2, 8'h07);
        wr(2'd0, 8'h16);
        idle(13);
        check("R7 long not yet", recovery_o, 0);
        idle(1);
        check("R7 long expired", recovery_o, 1);
        pulse_len(hi);
        check("R9 timeout pulse width", hi, RW);
        wr(2'd2, 8'h80);

        // R8 zero means 32 units: 128 cycles
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h17);
        idle(127);
        check("R8 not yet at 127", recovery_o, 0);
        idle(1);
        check("R8 expired at 128", recovery_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule